// File: doc/BRIEF.md
# Von Neumann Debiaser with Sparse-Bit Monitor

This block sits after a raw entropy source and removes bias from its bit stream. When debiasing is on, accepted raw bits are grouped two at a time. A pair of differing bits yields one output bit, which is the first bit of the pair. A pair of equal bits is dropped and yields nothing. When debiasing is off, every accepted bit is forwarded unchanged.

A long run of dropped pairs shows that the source has too little entropy. The block counts consecutive dropped pairs and compares that count with a programmable limit. When the count goes past the limit, a sticky error flag is raised.

A single register word is shared between two meanings, selected by a program-mode input:
- In program mode, it holds the 10-bit limit and can be written.
- Outside program mode, writes to it are ignored and a read returns a running count of raw samples.

Top module: `vn_debias_monitor`

## Requirements
- R1: With debiasing on and `run_en` high, every second accepted bit closes a pair. If the two bits differ, `out_valid` is high for one cycle, one clock after the closing bit is accepted, and `out_bit` equals the first bit of the pair (01 gives 0, 10 gives 1).
- R2: With debiasing on, an equal pair (00 or 11) and the first bit of any pair produce no `out_valid`.
- R3: With `vn_mode` low, each accepted bit appears on `out_bit` with `out_valid` high one clock later, and `sparse_err` never rises.
- R4: The run length increments on each equal pair and clears on each unequal pair. `sparse_err` is set when an equal pair takes the run length above the limit: a limit L tolerates L consecutive equal pairs and flags the pair numbered L+1.
- R5: `sparse_err` stays high until reset or until a rising edge of `prog_mode`. An unequal pair does not clear it.
- R6: After reset the limit is 63.
- R7: A write (`wr_en` high) loads `wr_data[9:0]` into the limit only while `prog_mode` is 1. Writes with `prog_mode` at 0 leave the limit unchanged.
- R8: A cycle with `rst_def` high returns the limit to 63. This takes priority over a write in the same cycle.
- R9: `rd_data` is registered and follows with one clock of latency:
  - with `prog_mode` at 1, it is the limit zero-extended, so bits 31:10 read as 0;
  - with `prog_mode` at 0, it is the raw-sample count zero-extended.
- R10: The raw-sample count increments on each cycle where `run_en` and `raw_valid` are both high. A cycle where `run_en` rises restarts it, and that cycle's own sample counts as the first.
- R11: The raw-sample count saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Generation active; while low, samples are ignored and the pair state is cleared |
| vn_mode | input | 1 | 1 = Von Neumann debiasing, 0 = pass-through |
| raw_valid | input | 1 | A raw bit is offered this cycle |
| raw_bit | input | 1 | Raw entropy bit |
| prog_mode | input | 1 | Program mode: enables limit writes and selects limit readback |
| rst_def | input | 1 | Return the limit to its default |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Registered readback: limit or sample count |
| out_valid | output | 1 | Debiased bit valid |
| out_bit | output | 1 | Debiased bit |
| sparse_err | output | 1 | Sticky insufficient-entropy flag |

## Verification
The assertions take the control inputs to be synchronous and free of X after reset. They also assume that `vn_mode` and the limit are not changed in the middle of a run whose result is being judged. The stimulus keeps to this:
- The limit is programmed only while `run_en` is low.
- A run is restarted before each scenario, so pairs start aligned.

The sweeps cover all four pair patterns and a long pseudo-random stream. They also cover several limits at the exact threshold and the counter saturation, using a narrow sample counter.

// File: rtl/vnd_pkg.sv
package vnd_pkg;
  localparam int unsigned VND_LIM_W   = 10;
  localparam int unsigned VND_CNT_W   = 20;
  localparam int unsigned VND_REG_W   = 32;
  localparam int unsigned VND_LIM_RST = 63;
endpackage

// File: rtl/vnd_pair_unit.sv
module vnd_pair_unit (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic vn_mode,
  input  logic raw_valid,
  input  logic raw_bit,
  output logic out_valid,
  output logic out_bit,
  output logic eq_pair,
  output logic neq_pair
);
  logic half_q;
  logic first_q;
  logic acc;

  always_comb begin
    acc      = run_en & raw_valid;
    eq_pair  = acc & vn_mode & half_q & (raw_bit == first_q);
    neq_pair = acc & vn_mode & half_q & (raw_bit != first_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q    <= 1'b0;
      first_q   <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!run_en || !vn_mode) half_q <= 1'b0;
      if (acc) begin
        if (!vn_mode) begin
          out_valid <= 1'b1;
          out_bit   <= raw_bit;
        end else if (!half_q) begin
          half_q  <= 1'b1;
          first_q <= raw_bit;
        end else begin
          half_q <= 1'b0;
          if (raw_bit != first_q) begin
            out_valid <= 1'b1;
            out_bit   <= first_q;
          end
        end
      end
    end
  end

  // R2
  first_half_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && vn_mode && !half_q) |=> !out_valid);
  // R2
  equal_pair_silent_chk: assert property (@(posedge clk) disable iff (rst)
    eq_pair |=> !out_valid);
  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !vn_mode) |=> (out_valid && out_bit == $past(raw_bit)));
endmodule

// File: rtl/vnd_sparse_mon.sv
module vnd_sparse_mon #(
  parameter int unsigned LIM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eq_pair,
  input  logic             neq_pair,
  input  logic             hold_clr,
  input  logic             err_clr,
  input  logic [LIM_W-1:0] limit,
  output logic             err
);
  localparam int unsigned RUN_W = LIM_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;

  always_comb begin
    run_nxt = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      err   <= 1'b0;
    end else begin
      if (neq_pair || hold_clr) run_q <= '0;
      else if (eq_pair)         run_q <= run_nxt;
      if (err_clr) err <= 1'b0;
      else if (eq_pair && ({1'b0, limit} < run_nxt)) err <= 1'b1;
    end
  end

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);
  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!err && !eq_pair) |=> !err);
  // R4
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    neq_pair |=> (run_q == '0));
endmodule

// File: rtl/vnd_regs.sv
module vnd_regs #(
  parameter int unsigned LIM_W   = 10,
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned LIM_RST = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_mode,
  input  logic             rst_def,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             run_en,
  input  logic             raw_valid,
  output logic [LIM_W-1:0] limit,
  output logic [REG_W-1:0] rd_data,
  output logic             prog_rise
);
  localparam logic [LIM_W-1:0] LIM_DEF = LIM_W'(LIM_RST);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prog_q;
  logic             run_q;
  logic [CNT_W-1:0] total_q;
  logic             restart;
  logic             acc;

  always_comb begin
    restart   = run_en & ~run_q;
    acc       = run_en & raw_valid;
    prog_rise = prog_mode & ~prog_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b0;
      run_q   <= 1'b0;
      limit   <= LIM_DEF;
      total_q <= '0;
      rd_data <= '0;
    end else begin
      prog_q <= prog_mode;
      run_q  <= run_en;
      if (rst_def)                limit <= LIM_DEF;
      else if (wr_en && prog_mode) limit <= wr_data[LIM_W-1:0];
      if (restart)                         total_q <= CNT_W'(acc);
      else if (acc && total_q != CNT_MAX)  total_q <= total_q + 1'b1;
      rd_data <= prog_mode ? REG_W'(limit) : REG_W'(total_q);
    end
  end

  // R7
  lim_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!prog_mode && !rst_def) |=> $stable(limit));
  // R9
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    prog_mode |=> (rd_data[REG_W-1:LIM_W] == '0));
  // R10
  total_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (total_q >= $past(total_q)));
endmodule

// File: rtl/vn_debias_monitor.sv
module vn_debias_monitor #(
  parameter int unsigned LIM_W   = vnd_pkg::VND_LIM_W,
  parameter int unsigned CNT_W   = vnd_pkg::VND_CNT_W,
  parameter int unsigned REG_W   = vnd_pkg::VND_REG_W,
  parameter int unsigned LIM_RST = vnd_pkg::VND_LIM_RST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             vn_mode,
  input  logic             raw_valid,
  input  logic             raw_bit,
  input  logic             prog_mode,
  input  logic             rst_def,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             out_valid,
  output logic             out_bit,
  output logic             sparse_err
);
  logic             eq_pair;
  logic             neq_pair;
  logic             prog_rise;
  logic             hold_clr;
  logic [LIM_W-1:0] limit;

  assign hold_clr = ~run_en | ~vn_mode;

  vnd_pair_unit u_pair (
    .clk(clk), .rst(rst), .run_en(run_en), .vn_mode(vn_mode),
    .raw_valid(raw_valid), .raw_bit(raw_bit),
    .out_valid(out_valid), .out_bit(out_bit),
    .eq_pair(eq_pair), .neq_pair(neq_pair)
  );

  vnd_sparse_mon #(.LIM_W(LIM_W)) u_mon (
    .clk(clk), .rst(rst), .eq_pair(eq_pair), .neq_pair(neq_pair),
    .hold_clr(hold_clr), .err_clr(prog_rise), .limit(limit),
    .err(sparse_err)
  );

  vnd_regs #(.LIM_W(LIM_W), .CNT_W(CNT_W), .REG_W(REG_W), .LIM_RST(LIM_RST)) u_regs (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .rst_def(rst_def),
    .wr_en(wr_en), .wr_data(wr_data), .run_en(run_en), .raw_valid(raw_valid),
    .limit(limit), .rd_data(rd_data), .prog_rise(prog_rise)
  );

  // R3
  no_err_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!vn_mode && !sparse_err) |=> !sparse_err);
endmodule

// File: tb/vn_debias_monitor_bench.sv
`timescale 1ns/1ps
module vn_debias_monitor_bench;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst, run_en, vn_mode, raw_valid, raw_bit, prog_mode, rst_def, wr_en;
  logic [31:0] wr_data, rd_data;
  logic out_valid, out_bit, sparse_err;
  int checks = 0, errors = 0;
  logic outs [0:1023];
  int n_out = 0;
  logic sent [0:1023];

  always #2.5 clk = ~clk;

  vn_debias_monitor #(.CNT_W(CW)) u_vn_debias_monitor (
    .clk(clk), .rst(rst), .run_en(run_en), .vn_mode(vn_mode),
    .raw_valid(raw_valid), .raw_bit(raw_bit), .prog_mode(prog_mode),
    .rst_def(rst_def), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .out_valid(out_valid), .out_bit(out_bit), .sparse_err(sparse_err)
  );

  always @(negedge clk) if (!rst && out_valid) begin
    if (n_out < 1024) outs[n_out] = out_bit;
    n_out++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(input logic b);
    raw_valid = 1'b1; raw_bit = b;
    tick();
    raw_valid = 1'b0;
  endtask

  task automatic write_reg(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic read_reg(output logic [31:0] v);
    tick(); tick(); v = rd_data;
  endtask

  task automatic restart_run();
    run_en = 1'b0; tick(); run_en = 1'b1; tick();
  endtask

  task automatic set_limit(input int l);
    run_en = 1'b0; prog_mode = 1'b0; tick();
    prog_mode = 1'b1; write_reg(32'(l)); prog_mode = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] lfsr;
    int ne;
    int lims [5] = '{0, 1, 2, 5, 9};
    rst = 1; run_en = 0; vn_mode = 1; raw_valid = 0; raw_bit = 0;
    prog_mode = 0; rst_def = 0; wr_en = 0; wr_data = '0;
    repeat (3) tick();
    rst = 0; tick();
    chk(!out_valid && !sparse_err, "R6 reset outputs", {out_valid, sparse_err}, 0);
    // R6 / R9 default limit readback
    prog_mode = 1; read_reg(v);
    chk(v == 63, "R6 default limit", v, 63);
    // R7 write ignored outside program mode
    prog_mode = 0; tick(); write_reg(100);
    prog_mode = 1; read_reg(v);
    chk(v == 63, "R7 write ignored", v, 63);
    write_reg(5); read_reg(v);
    chk(v == 5, "R7 write in program mode", v, 5);
    // R9 upper bits zero
    write_reg(32'hFFFF_FFFF); read_reg(v);
    chk(v == 32'h3FF, "R9 upper bits zero", v, 32'h3FF);
    // R8 restore default, priority over write
    rst_def = 1; write_reg(7); rst_def = 0; read_reg(v);
    chk(v == 63, "R8 restore default", v, 63);
    prog_mode = 0; tick();

    // R1 R2 exhaustive pair patterns
    vn_mode = 1; restart_run();
    for (int p = 0; p < 4; p++) begin
      n_out = 0;
      send(p[1]); send(p[0]); tick();
      ne = (p[1] != p[0]) ? 1 : 0;
      chk(n_out == ne, "R2 pair output count", n_out, ne);
      if (ne == 1) chk(outs[0] == p[1], "R1 first bit of pair", outs[0], p[1]);
    end

    // R1 pseudo-random stream against model
    lfsr = 16'hACE1; n_out = 0;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sent[i] = lfsr[0]; send(lfsr[0]);
    end
    tick();
    ne = 0;
    for (int k = 0; k < 200; k++) if (sent[2*k] != sent[2*k+1]) begin
      if (ne < n_out && outs[ne] != sent[2*k])
        chk(0, "R1 stream bit", outs[ne], sent[2*k]);
      ne++;
    end
    chk(n_out == ne, "R1 stream count", n_out, ne);

    // R3 pass-through, sparse check inactive
    set_limit(0); vn_mode = 0; restart_run(); n_out = 0;
    for (int i = 0; i < 40; i++) begin sent[i] = (i % 3 == 0); send(sent[i]); end
    tick();
    chk(n_out == 40, "R3 pass-through count", n_out, 40);
    for (int i = 0; i < 40; i++)
      if (i < n_out && outs[i] != sent[i]) chk(0, "R3 pass-through bit", outs[i], sent[i]);
    for (int i = 0; i < 50; i++) send(1'b0);
    tick();
    chk(!sparse_err, "R3 no error in pass-through", sparse_err, 0);

    // R4 R5 threshold sweep
    vn_mode = 1;
    foreach (lims[j]) begin
      set_limit(lims[j]); restart_run();
      for (int i = 0; i < lims[j]; i++) begin send(1); send(1); end
      tick();
      chk(!sparse_err, "R4 at limit no error", sparse_err, 0);
      send(0); send(1);
      for (int i = 0; i < lims[j]; i++) begin send(0); send(0); end
      tick();
      chk(!sparse_err, "R4 run cleared by unequal pair", sparse_err, 0);
      send(0); send(0); tick();
      chk(sparse_err, "R4 limit exceeded", sparse_err, 1);
      send(1); send(0); tick();
      chk(sparse_err, "R5 sticky after unequal", sparse_err, 1);
      prog_mode = 1; tick(); tick();
      chk(!sparse_err, "R5 cleared on program entry", sparse_err, 0);
      prog_mode = 0; tick();
    end

    // R10 sample count
    restart_run();
    for (int i = 0; i < 37; i++) send(i[0]);
    read_reg(v);
    chk(v == 37, "R10 sample count", v, 37);
    run_en = 0;
    for (int i = 0; i < 5; i++) send(1);
    read_reg(v);
    chk(v == 37, "R10 idle samples ignored", v, 37);
    restart_run(); read_reg(v);
    chk(v == 0, "R10 restart clears", v, 0);
    // R11 saturation
    for (int i = 0; i < 300; i++) send(i[1]);
    read_reg(v);
    chk(v == 255, "R11 saturation", v, 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule